// File: doc/BRIEF.md
# System Clock Source Controller

This block chooses where the system clock comes from and how fast it runs. Software programs it through a small register port. A primary configuration register holds the bypass, PLL power-down, divider-use, oscillator-source, crystal and divider fields. A secondary register has an override bit. When that bit is set, the secondary register's bypass, power-down, oscillator-source and divider fields take the place of the primary ones. The divider-use and crystal fields always come from the primary register.

The PLL is modelled by a lock counter. Lock comes a fixed number of cycles after the PLL is powered up. It is lost at once on power-down or when the crystal value changes. The system moves onto the PLL only when bypass is clear and the PLL is locked. Software can therefore power the PLL, set it up and clear bypass in any order, and the switch still happens cleanly. A sticky lock status bit, cleared by writing 1, drives a maskable interrupt. The divider does not produce a gated clock. It produces a one-cycle clock-enable pulse.

The intended bring-up order is:
1. Set bypass and clear divider-use.
2. Program the crystal and the source, and clear power-down.
3. Program the divider and set divider-use.
4. Poll for lock.
5. Clear bypass.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, both configuration registers read 0x3 (bypass=1, power-down=1), and the mask and status registers read 0. The outputs are then: `sel_pll_o`=0, `pll_pwrdn_o`=1, `div_en_o`=0, `clk_en_o`=1 and `irq_o`=0. Lock never arrives while the PLL stays powered down.
- R2: Writes take effect at the clock edge and read back combinationally. The four registers are:
  - Address 0, primary. Bits: bit0 bypass, bit1 power-down, bit2 divider-use, [5:4] oscillator source, [11:8] crystal, [19:16] divider. Writable mask 0x000F0F37.
  - Address 1, secondary. Bits: bit31 override, bit0 bypass, bit1 power-down, [5:4] oscillator source, [19:16] divider. Writable mask 0x800F0033.
  - Address 2, interrupt mask (bit0).
  - Address 3, status: bit0 sticky lock, bit1 live lock.
- R3: With override set, the effective bypass, power-down, oscillator source and divider come from the secondary register. Divider-use and crystal always come from the primary register.
- R4: Live lock rises exactly LOCK_CYC clock edges after the edge that clears the effective power-down.
- R5: Live lock drops at once when the effective power-down is set, and when a write changes the crystal field. Rewriting the same crystal value does not disturb lock.
- R6: `sel_pll_o` is 1 only when the effective bypass is clear and the PLL is locked. Clearing bypass before lock keeps the raw clock until lock arrives.
- R7: With divider-use clear, `clk_en_o` is high every cycle. With it set, `clk_en_o` pulses once every (divider + 1) cycles.
- R8: The sticky lock bit sets one cycle after live lock rises. Writing 1 to status bit0 clears it. Writing 0 has no effect.
- R9: `irq_o` equals the sticky lock bit AND mask bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| sel_pll_o | output | 1 | 1: system runs on PLL, 0: raw oscillator |
| osc_src_o | output | 2 | Effective oscillator source select |
| pll_pwrdn_o | output | 1 | Effective PLL power-down |
| xtal_o | output | XTAL_W | Crystal configuration to PLL |
| div_en_o | output | 1 | System divider in use |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| irq_o | output | 1 | Masked lock interrupt |

## Verification
The bench counts edges from the write that powers the PLL. It then checks that lock and the PLL select appear on exactly the LOCK_CYC-th edge: a design off by one would switch early or late. Bypass is cleared before lock, so a design that switches onto an unlocked PLL shows `sel_pll_o` high too soon. Random pairs of primary and secondary values check which fields the override takes over; a design that overrode divider-use or crystal would show the wrong `div_en_o` or `xtal_o`. The bench also measures divider pulse spacing, including divider 0. It checks that a write of 0 leaves the sticky bit alone, and that a crystal rewrite drops lock while a same-value write does not.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned OSC_LSB = 4;
  localparam int unsigned XTAL_LSB = 8;
  localparam int unsigned DIV_LSB = 16;
  localparam int unsigned OVR_BIT = 31;

  typedef enum logic [1:0] {
    A_PRI  = 2'd0,
    A_SEC  = 2'd1,
    A_MASK = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/clk_src_regs.sv
module clk_src_regs
  import clk_src_pkg::*;
#(
  parameter int unsigned XTAL_W = 4,
  parameter int unsigned DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              p_bypass_o,
  output logic              p_pwrdn_o,
  output logic              p_use_div_o,
  output logic [1:0]        p_osc_o,
  output logic [XTAL_W-1:0] p_xtal_o,
  output logic [DIV_W-1:0]  p_div_o,
  output logic              s_ovr_o,
  output logic              s_bypass_o,
  output logic              s_pwrdn_o,
  output logic [1:0]        s_osc_o,
  output logic [DIV_W-1:0]  s_div_o,
  output logic              relock_o,
  output logic              sticky_o,
  output logic              irq_o
);
  logic mask_q, lock_q;
  logic wr_pri, wr_sec, wr_mask, wr_stat;

  assign wr_pri  = wr_en_i && (addr_i == A_PRI);
  assign wr_sec  = wr_en_i && (addr_i == A_SEC);
  assign wr_mask = wr_en_i && (addr_i == A_MASK);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);

  // new crystal value restarts PLL acquisition
  assign relock_o = wr_pri && (wdata_i[XTAL_LSB +: XTAL_W] != p_xtal_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_bypass_o  <= 1'b1;
      p_pwrdn_o   <= 1'b1;
      p_use_div_o <= 1'b0;
      p_osc_o     <= '0;
      p_xtal_o    <= '0;
      p_div_o     <= '0;
      s_ovr_o     <= 1'b0;
      s_bypass_o  <= 1'b1;
      s_pwrdn_o   <= 1'b1;
      s_osc_o     <= '0;
      s_div_o     <= '0;
      mask_q      <= 1'b0;
    end else begin
      if (wr_pri) begin
        p_bypass_o  <= wdata_i[0];
        p_pwrdn_o   <= wdata_i[1];
        p_use_div_o <= wdata_i[2];
        p_osc_o     <= wdata_i[OSC_LSB +: 2];
        p_xtal_o    <= wdata_i[XTAL_LSB +: XTAL_W];
        p_div_o     <= wdata_i[DIV_LSB +: DIV_W];
      end
      if (wr_sec) begin
        s_ovr_o    <= wdata_i[OVR_BIT];
        s_bypass_o <= wdata_i[0];
        s_pwrdn_o  <= wdata_i[1];
        s_osc_o    <= wdata_i[OSC_LSB +: 2];
        s_div_o    <= wdata_i[DIV_LSB +: DIV_W];
      end
      if (wr_mask) mask_q <= wdata_i[0];
    end
  end

  // sticky lock: set on rising lock, set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      lock_q <= lock_i;
      if (lock_i && !lock_q)         sticky_o <= 1'b1;
      else if (wr_stat && wdata_i[0]) sticky_o <= 1'b0;
    end
  end

  assign irq_o = sticky_o & mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PRI: begin
        rdata_o[0] = p_bypass_o;
        rdata_o[1] = p_pwrdn_o;
        rdata_o[2] = p_use_div_o;
        rdata_o[OSC_LSB +: 2]       = p_osc_o;
        rdata_o[XTAL_LSB +: XTAL_W] = p_xtal_o;
        rdata_o[DIV_LSB +: DIV_W]   = p_div_o;
      end
      A_SEC: begin
        rdata_o[OVR_BIT] = s_ovr_o;
        rdata_o[0] = s_bypass_o;
        rdata_o[1] = s_pwrdn_o;
        rdata_o[OSC_LSB +: 2]     = s_osc_o;
        rdata_o[DIV_LSB +: DIV_W] = s_div_o;
      end
      A_MASK:  rdata_o[0] = mask_q;
      default: rdata_o[1:0] = {lock_i, sticky_o};
    endcase
  end
endmodule

// File: rtl/clk_src_pll.sv
module clk_src_pll #(
  parameter int unsigned LOCK_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_i,
  input  logic relock_i,
  output logic lock_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LOCK_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (pwrdn_i || relock_i) cnt_q <= '0;
    else if (cnt_q != LIM)        cnt_q <= cnt_q + 1'b1;
  end

  // power-down kills lock without waiting for an edge
  assign lock_o = (cnt_q == LIM) && !pwrdn_i;
endmodule

// File: rtl/clk_src_div.sv
module clk_src_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // >= so a shrinking divider wraps at once
  assign wrap = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || wrap) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = !en_i || wrap;
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int unsigned XTAL_W   = 4,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned LOCK_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_pll_o,
  output logic [1:0]        osc_src_o,
  output logic              pll_pwrdn_o,
  output logic [XTAL_W-1:0] xtal_o,
  output logic              div_en_o,
  output logic              clk_en_o,
  output logic              irq_o
);
  logic              p_bypass, p_pwrdn, p_use_div;
  logic [1:0]        p_osc, s_osc;
  logic [DIV_W-1:0]  p_div, s_div, eff_div;
  logic              s_ovr, s_bypass, s_pwrdn;
  logic              eff_bypass;
  logic              relock, pll_lock, sticky;

  clk_src_regs #(.XTAL_W(XTAL_W), .DIV_W(DIV_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .lock_i     (pll_lock),
    .rdata_o    (rdata_o),
    .p_bypass_o (p_bypass),
    .p_pwrdn_o  (p_pwrdn),
    .p_use_div_o(p_use_div),
    .p_osc_o    (p_osc),
    .p_xtal_o   (xtal_o),
    .p_div_o    (p_div),
    .s_ovr_o    (s_ovr),
    .s_bypass_o (s_bypass),
    .s_pwrdn_o  (s_pwrdn),
    .s_osc_o    (s_osc),
    .s_div_o    (s_div),
    .relock_o   (relock),
    .sticky_o   (sticky),
    .irq_o      (irq_o)
  );

  // secondary register takes over when its override bit is set
  assign eff_bypass  = s_ovr ? s_bypass : p_bypass;
  assign pll_pwrdn_o = s_ovr ? s_pwrdn  : p_pwrdn;
  assign osc_src_o   = s_ovr ? s_osc    : p_osc;
  assign eff_div     = s_ovr ? s_div    : p_div;
  assign div_en_o    = p_use_div;

  clk_src_pll #(.LOCK_CYC(LOCK_CYC)) u_pll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwrdn_i (pll_pwrdn_o),
    .relock_i(relock),
    .lock_o  (pll_lock)
  );

  clk_src_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (div_en_o),
    .div_i  (eff_div),
    .pulse_o(clk_en_o)
  );

  assign sel_pll_o = !eff_bypass && pll_lock;
endmodule

// File: rtl/clk_src_chk.sv
module clk_src_chk #(
  parameter int unsigned XTAL_W   = 4,
  parameter int unsigned LOCK_CYC = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_pll_o,
  input logic              pll_pwrdn_o,
  input logic [XTAL_W-1:0] xtal_o,
  input logic              div_en_o,
  input logic              clk_en_o,
  input logic              irq_o,
  input logic              pll_lock,
  input logic              sticky
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LOCK_CYC);

  logic             past_ok;
  logic [CNT_W-1:0] pw_cnt;

  // powered-cycle counter, window checked without deep $past
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok <= 1'b0;
      pw_cnt  <= '0;
    end else begin
      past_ok <= 1'b1;
      if (pll_pwrdn_o)     pw_cnt <= '0;
      else if (pw_cnt != LIM) pw_cnt <= pw_cnt + 1'b1;
    end
  end

  p_lock_time_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_lock |-> (pw_cnt == LIM));

  p_pwrdn_unlock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_pwrdn_o |-> !pll_lock);

  p_xtal_unlock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (xtal_o != $past(xtal_o))) |-> !pll_lock);

  p_sel_powered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_pll_o |-> !pll_pwrdn_o);

  p_nodiv_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_en_o |-> clk_en_o);

  p_sticky_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(pll_lock)) |=> sticky);

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sticky);
endmodule

bind clk_src_ctrl clk_src_chk #(.XTAL_W(XTAL_W), .LOCK_CYC(LOCK_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_pll_o  (sel_pll_o),
  .pll_pwrdn_o(pll_pwrdn_o),
  .xtal_o     (xtal_o),
  .div_en_o   (div_en_o),
  .clk_en_o   (clk_en_o),
  .irq_o      (irq_o),
  .pll_lock   (pll_lock),
  .sticky     (sticky)
);

// File: tb/sim_clk_src_ctrl.sv
`timescale 1ns/1ps
module sim_clk_src_ctrl;
  localparam int L = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sel_pll_o, pll_pwrdn_o, div_en_o, clk_en_o, irq_o;
  logic [1:0]  osc_src_o;
  logic [3:0]  xtal_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  clk_src_ctrl #(.XTAL_W(4), .DIV_W(4), .LOCK_CYC(L)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .sel_pll_o(sel_pll_o),
    .osc_src_o(osc_src_o), .pll_pwrdn_o(pll_pwrdn_o), .xtal_o(xtal_o),
    .div_en_o(div_en_o), .clk_en_o(clk_en_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic f_pwrdn(input logic [31:0] p, input logic [31:0] s);
    return s[31] ? s[1] : p[1];
  endfunction
  function automatic logic f_bypass(input logic [31:0] p, input logic [31:0] s);
    return s[31] ? s[0] : p[0];
  endfunction
  function automatic logic [1:0] f_osc(input logic [31:0] p, input logic [31:0] s);
    return s[31] ? s[5:4] : p[5:4];
  endfunction

  // cycles between successive clk_en pulses
  task automatic period(output int k);
    while (clk_en_o !== 1'b1) @(negedge clk_i);
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (clk_en_o !== 1'b1 && k < 64);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, p, s;
    int k;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(2'd0, v); check("R1 pri", v, 32'h3);
    rd(2'd1, v); check("R1 sec", v, 32'h3);
    rd(2'd2, v); check("R1 mask", v, 32'h0);
    check("R1 outs", {sel_pll_o, pll_pwrdn_o, div_en_o, clk_en_o, irq_o}, 5'b01010);
    repeat (L + 5) @(negedge clk_i);
    rd(2'd3, v); check("R1 no lock while powered down", v, 32'h0);

    // R2 readback masks
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R2 pri mask", v, 32'h000F_0F37);
    wr(2'd1, 32'h7FFF_FFFF); rd(2'd1, v); check("R2 sec mask", v, 32'h000F_0033);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R2 mask reg", v, 32'h1);
    wr(2'd2, 32'h0);

    // R3 random override mixing
    for (int i = 0; i < 30; i++) begin
      p = $urandom; s = $urandom;
      wr(2'd0, p); wr(2'd1, s);
      check("R3 pwrdn", pll_pwrdn_o, f_pwrdn(p, s));
      check("R3 osc", osc_src_o, f_osc(p, s));
      check("R3 use_div from primary", div_en_o, p[2]);
      check("R3 xtal from primary", xtal_o, p[11:8]);
      if (f_bypass(p, s)) check("R6 bypass keeps raw", sel_pll_o, 1'b0);
      if (!p[2]) check("R7 no divider", clk_en_o, 1'b1);
    end

    // R7 divider periods
    wr(2'd1, 32'h3);
    foreach (k_list[j]) begin
      wr(2'd0, 32'h7 | (32'(k_list[j]) << 16));
      period(k); period(k);
      check("R7 period", k, k_list[j] + 1);
    end
    for (int i = 0; i < 4; i++) begin
      v = $urandom % 16;
      wr(2'd0, 32'h7 | (v << 16));
      period(k); period(k);
      check("R7 random period", k, v + 1);
    end
    wr(2'd0, 32'h0009_0007);
    wr(2'd1, 32'h8003_0003);
    period(k); period(k);
    check("R3 override divider", k, 4);

    // R4 R6 lock sequence, bypass cleared early
    wr(2'd1, 32'h3);
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0000_0503);
    wr(2'd0, 32'h0000_0500);
    for (int j = 1; j < L; j++) begin
      @(negedge clk_i);
      if (j == 1 || j == L - 1) check("R6 raw until lock", sel_pll_o, 1'b0);
    end
    rd(2'd3, v); check("R4 not locked at L-1", v, 32'h0);
    @(negedge clk_i);
    rd(2'd3, v); check("R4 locked at L", v[1], 1'b1);
    check("R6 on PLL after lock", sel_pll_o, 1'b1);
    @(negedge clk_i);
    rd(2'd3, v); check("R8 sticky set", v, 32'h3);
    check("R9 irq", irq_o, 1'b1);

    // R8 write-0 ignored, write-1 clears
    wr(2'd3, 32'h0); rd(2'd3, v); check("R8 write 0 ignored", v, 32'h3);
    wr(2'd3, 32'h1); rd(2'd3, v); check("R8 w1c", v, 32'h2);
    check("R9 irq cleared", irq_o, 1'b0);

    // R5 same crystal keeps lock, new crystal drops it
    wr(2'd0, 32'h0000_0500); rd(2'd3, v); check("R5 same xtal keeps lock", v[1], 1'b1);
    wr(2'd0, 32'h0000_0600); rd(2'd3, v); check("R5 xtal change drops lock", v[1], 1'b0);
    check("R6 back to raw", sel_pll_o, 1'b0);
    repeat (L + 2) @(negedge clk_i);
    rd(2'd3, v); check("R4 relocked", v, 32'h3);

    // R9 mask off hides sticky
    wr(2'd2, 32'h0); check("R9 masked", irq_o, 1'b0);

    // R5 power-down via override
    wr(2'd1, 32'h8000_0002);
    rd(2'd3, v); check("R5 pwrdn drops lock", v[1], 1'b0);
    check("R5 pwrdn out", pll_pwrdn_o, 1'b1);
    check("R6 sel off", sel_pll_o, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  int k_list[4] = '{0, 1, 5, 15};
endmodule